// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block produces horizontal and vertical raster timing for a display. Software programs it through a small word-addressed register port. A pixel counter and a line counter drive a set of window comparators. Each boundary of the raster sits in its own programmed start/end pair: active region and total, blanking window, sync pulse, and a separate sync pair for a flat panel. The outputs are hsync, vsync, blank, display-enable and the two flat-panel syncs, together with the live counter values.

Every timing register is 32 bits wide and holds two 16-bit fields, each stored as its quantity minus one. Writes to the control register and the timing registers are refused until software writes a magic unlock word to the unlock register. Writing zero locks them again. Timing changes made while the raster runs are held in the programmed copy. They move into the working copy only as the frame wraps, so a frame never mixes old and new timing. The register port and the counters share one clock, the pixel clock.

Top module: `rasterTimingGen`

## Requirements
- R1: After reset all registers read zero, the bank is locked, both counters are 0, blank is 1 and hsync, vsync, de, fpHsync and fpVsync are 0.
- R2: A write to address 0 with the value UNLOCK_CODE unlocks the bank, and a write of 0 to address 0 locks it. Any other value written there leaves the lock state unchanged. Reading address 0 returns the unlocked flag in bit 0. While the bank is locked, writes to addresses 1 to 9 do not change any register.
- R3: Reads return the stored value whether or not the bank is locked. Address 1 is the control word, zero-extended. Addresses 2 to 9 are the timing words, in this order: horizontal active/total, horizontal blank, horizontal sync, flat-panel horizontal sync, vertical active/total, vertical blank, vertical sync, flat-panel vertical sync. In each word bits 15:0 hold the first field and bits 31:16 the second. Addresses 10 to 15 read as 0.
- R4: While running, the pixel counter counts 0 up to the working horizontal total field, then wraps to 0. The line counter advances on each pixel wrap and wraps to 0 after the working vertical total field.
- R5: While control bit 0 (timing enable) is clear, both counters stay at 0, blank is 1 and all sync outputs and de are 0. After control bit 0 is written to 1, the counters read 0 in the cycle after the write and advance by one per cycle from there.
- R6: blank is 1 when control bits 0 and 1 (blank enable) are not both set. It is also 1 when the pixel count is greater than the horizontal blank low field and at most its high field, or when the line count meets the same rule against the vertical blank word.
- R7: de is 1 exactly when control bits 0 and 1 are set, the pixel count is at most the horizontal active field, and the line count is at most the vertical active field.
- R8: hsync is 1 exactly when control bits 0 and 2 are set and the pixel count is greater than the horizontal sync low field and at most its high field. vsync follows the same rule with control bit 3, the line count and the vertical sync word.
- R9: fpHsync and fpVsync follow the same window rule against their own flat-panel words, gated by control bits 0 and 4, independently of the CRT sync words.
- R10: A timing word written while the raster runs takes effect in the cycle in which both counters wrap to 0. Control bits take effect in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, also clocks the register port |
| rst | input | 1 | Synchronous reset, active high |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register word address for write and read |
| regWrData | input | 2*FIELD_W | Write data |
| regRdData | output | 2*FIELD_W | Combinational read data for regAddr |
| hsync | output | 1 | CRT horizontal sync, active high |
| vsync | output | 1 | CRT vertical sync, active high |
| fpHsync | output | 1 | Flat-panel horizontal sync |
| fpVsync | output | 1 | Flat-panel vertical sync |
| blank | output | 1 | Blanking, 1 = output blanked |
| de | output | 1 | Display enable, 1 inside the active region |
| hCnt | output | FIELD_W | Current pixel count |
| vCnt | output | FIELD_W | Current line count |

## Verification
The hardest case to reach is a timing write that lands in the middle of a running frame. Its read-back must change at once, while the raster keeps the old geometry until the frame wraps. The same holds for a locked write issued while the raster runs. The stimulus drives these writes at arbitrary cycles of a live frame, including changes to the vertical total and the sync windows. A cycle-accurate model in the bench keeps its own programmed and working copies. The scoreboard compares every output in every cycle against that model, across several frames after each write.

// File: rtl/tgPkg.sv
package tgPkg;
  localparam int NUM_TIMING   = 8;
  localparam int HALF_TIMING  = NUM_TIMING / 2;
  localparam int REG_UNLOCK   = 0;
  localparam int REG_CTRL     = 1;
  localparam int REG_TIM_BASE = 2;
  localparam int CTRL_W       = 5;
  // timing word indices (address = REG_TIM_BASE + index)
  localparam int T_H_ACT = 0;
  localparam int T_V_ACT = 4;

  typedef struct packed {
    logic runEn;
    logic loadShadow;
  } tgStrobe_t;
endpackage

// File: rtl/tgCtrl.sv
module tgCtrl
  import tgPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int ADDR_W  = 4,
  parameter logic [2*FIELD_W-1:0] UNLOCK_CODE = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [2*FIELD_W-1:0] regWrData,
  output logic [2*FIELD_W-1:0] regRdData,
  input  logic                 frameWrap,
  output tgStrobe_t            strobe,
  output logic [CTRL_W-2:0]    outEn,
  output logic [NUM_TIMING-1:0][2*FIELD_W-1:0] progTiming
);
  localparam int DW = 2 * FIELD_W;

  logic              unlocked;
  logic [CTRL_W-1:0] ctrlReg;
  logic              wrOpen;

  assign wrOpen = regWrEn && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked   <= 1'b0;
      ctrlReg    <= '0;
      progTiming <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_W'(REG_UNLOCK)) begin
        if (regWrData == UNLOCK_CODE) unlocked <= 1'b1;
        else if (regWrData == '0)     unlocked <= 1'b0;
      end
      if (wrOpen && regAddr == ADDR_W'(REG_CTRL)) ctrlReg <= regWrData[CTRL_W-1:0];
      for (int i = 0; i < NUM_TIMING; i++) begin
        if (wrOpen && regAddr == ADDR_W'(REG_TIM_BASE + i)) progTiming[i] <= regWrData;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(REG_UNLOCK)) regRdData = DW'(unlocked);
    if (regAddr == ADDR_W'(REG_CTRL))   regRdData = DW'(ctrlReg);
    for (int i = 0; i < NUM_TIMING; i++) begin
      if (regAddr == ADDR_W'(REG_TIM_BASE + i)) regRdData = progTiming[i];
    end
  end

  // working copy follows programmed copy while stopped, or at frame wrap
  assign strobe.runEn      = ctrlReg[0];
  assign strobe.loadShadow = !ctrlReg[0] || frameWrap;
  assign outEn             = ctrlReg[CTRL_W-1:1];

  // R2: a locked write leaves control and timing untouched
  assert_locked_write_R2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && !unlocked && regAddr != ADDR_W'(REG_UNLOCK))
      |=> ($stable(ctrlReg) && $stable(progTiming)));

  // R2: writing zero to the unlock word relocks
  assert_relock_R2: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == ADDR_W'(REG_UNLOCK) && regWrData == '0) |=> !unlocked);
endmodule

// File: rtl/tgPath.sv
module tgPath
  import tgPkg::*;
#(
  parameter int FIELD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  tgStrobe_t         strobe,
  input  logic [CTRL_W-2:0] outEn,
  input  logic [NUM_TIMING-1:0][2*FIELD_W-1:0] progTiming,
  output logic              frameWrap,
  output logic [FIELD_W-1:0] hCnt,
  output logic [FIELD_W-1:0] vCnt,
  output logic              hsync,
  output logic              vsync,
  output logic              fpHsync,
  output logic              fpVsync,
  output logic              blank,
  output logic              de
);
  logic [NUM_TIMING-1:0][2*FIELD_W-1:0] work;
  logic [NUM_TIMING-1:0] hit;
  logic hWrap, vWrap, showEn;

  assign hWrap     = hCnt >= work[T_H_ACT][2*FIELD_W-1:FIELD_W];
  assign vWrap     = vCnt >= work[T_V_ACT][2*FIELD_W-1:FIELD_W];
  assign frameWrap = hWrap && vWrap;

  always_ff @(posedge clk) begin
    if (rst)                    work <= '0;
    else if (strobe.loadShadow) work <= progTiming;
  end

  always_ff @(posedge clk) begin
    if (rst || !strobe.runEn) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (hWrap) begin
      hCnt <= '0;
      vCnt <= vWrap ? '0 : vCnt + 1'b1;
    end else begin
      hCnt <= hCnt + 1'b1;
    end
  end

  // one comparator per timing word: active-limit for index 0/4, window otherwise
  for (genvar g = 0; g < NUM_TIMING; g++) begin : gWin
    logic [FIELD_W-1:0] cnt, loF;
    assign cnt = (g < HALF_TIMING) ? hCnt : vCnt;
    assign loF = work[g][FIELD_W-1:0];
    if (g % HALF_TIMING == 0) begin : gAct
      assign hit[g] = cnt <= loF;
    end else begin : gPair
      logic [FIELD_W-1:0] hiF;
      assign hiF    = work[g][2*FIELD_W-1:FIELD_W];
      assign hit[g] = (cnt > loF) && (cnt <= hiF);
    end
  end

  assign showEn  = strobe.runEn && outEn[0];
  assign blank   = !showEn || hit[1] || hit[5];
  assign de      = showEn && hit[0] && hit[4];
  assign hsync   = strobe.runEn && outEn[1] && hit[2];
  assign vsync   = strobe.runEn && outEn[2] && hit[6];
  assign fpHsync = strobe.runEn && outEn[3] && hit[3];
  assign fpVsync = strobe.runEn && outEn[3] && hit[7];

  // R4: pixel counter steps by one below the total
  assert_hstep_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.runEn && !hWrap) |=> (hCnt == $past(hCnt) + 1'b1));

  // R4: pixel counter wraps at the total
  assert_hwrap_R4: assert property (@(posedge clk) disable iff (rst)
    (strobe.runEn && hWrap) |=> (hCnt == '0));

  // R5: stopped generator holds both counters at zero
  assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
    !strobe.runEn |=> (hCnt == '0 && vCnt == '0));

  // R10: working copy only moves at a frame wrap while running
  assert_shadow_R10: assert property (@(posedge clk) disable iff (rst)
    (strobe.runEn && !frameWrap) |=> $stable(work));
endmodule

// File: rtl/rasterTimingGen.sv
module rasterTimingGen
  import tgPkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int ADDR_W  = 4,
  parameter logic [2*FIELD_W-1:0] UNLOCK_CODE = 32'h5A3C_0F96
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [2*FIELD_W-1:0] regWrData,
  output logic [2*FIELD_W-1:0] regRdData,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 fpHsync,
  output logic                 fpVsync,
  output logic                 blank,
  output logic                 de,
  output logic [FIELD_W-1:0]   hCnt,
  output logic [FIELD_W-1:0]   vCnt
);
  tgStrobe_t         strobe;
  logic [CTRL_W-2:0] outEn;
  logic              frameWrap;
  logic [NUM_TIMING-1:0][2*FIELD_W-1:0] progTiming;

  tgCtrl #(.FIELD_W(FIELD_W), .ADDR_W(ADDR_W), .UNLOCK_CODE(UNLOCK_CODE)) uCtrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameWrap(frameWrap),
    .strobe(strobe), .outEn(outEn), .progTiming(progTiming)
  );

  tgPath #(.FIELD_W(FIELD_W)) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .outEn(outEn),
    .progTiming(progTiming), .frameWrap(frameWrap), .hCnt(hCnt), .vCnt(vCnt),
    .hsync(hsync), .vsync(vsync), .fpHsync(fpHsync), .fpVsync(fpVsync),
    .blank(blank), .de(de)
  );
endmodule

// File: tb/sim_rasterTimingGen.sv
`timescale 1ns/1ps
module sim_rasterTimingGen;
  localparam logic [31:0] CODE = 32'h5A3C_0F96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic regWrEn = 1'b0;
  logic [3:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic hsync, vsync, fpHsync, fpVsync, blank, de;
  logic [15:0] hCnt, vCnt;

  always #5 clk = ~clk;

  rasterTimingGen #(.FIELD_W(16), .ADDR_W(4), .UNLOCK_CODE(CODE)) u0 (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hsync(hsync), .vsync(vsync),
    .fpHsync(fpHsync), .fpVsync(fpVsync), .blank(blank), .de(de),
    .hCnt(hCnt), .vCnt(vCnt)
  );

  typedef struct {
    logic [15:0] h, v;
    logic bl, de, hs, vs, fh, fv, tg;
    string tag;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the block, built from the requirements
  logic mUnl = 0;
  logic [4:0] mCtrl = '0;
  logic [31:0] mProg[8];
  logic [31:0] mWork[8];
  logic [15:0] mH = '0, mV = '0;
  string phase = "R5";

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic inWin(logic [15:0] c, logic [31:0] r);
    return (c > r[15:0]) && (c <= r[31:16]);
  endfunction

  function automatic exp_t mkExp();
    exp_t e;
    logic tg;
    tg = mCtrl[0];
    e.h  = mH;
    e.v  = mV;
    e.tg = tg;
    e.bl = !(tg && mCtrl[1]) || inWin(mH, mWork[1]) || inWin(mV, mWork[5]);
    e.de = tg && mCtrl[1] && (mH <= mWork[0][15:0]) && (mV <= mWork[4][15:0]);
    e.hs = tg && mCtrl[2] && inWin(mH, mWork[2]);
    e.vs = tg && mCtrl[3] && inWin(mV, mWork[6]);
    e.fh = tg && mCtrl[4] && inWin(mH, mWork[3]);
    e.fv = tg && mCtrl[4] && inWin(mV, mWork[7]);
    e.tag = phase;
    return e;
  endfunction

  task automatic modelEdge(logic we, logic [3:0] a, logic [31:0] d);
    logic oldTg, oldUnl, fe;
    logic [15:0] oh, ov;
    oldTg = mCtrl[0];
    oldUnl = mUnl;
    oh = mH;
    ov = mV;
    fe = (oh >= mWork[0][31:16]) && (ov >= mWork[4][31:16]);
    if (!oldTg) begin
      mH = 0; mV = 0;
    end else if (oh >= mWork[0][31:16]) begin
      mH = 0;
      mV = (ov >= mWork[4][31:16]) ? 16'd0 : ov + 16'd1;
    end else begin
      mH = oh + 16'd1;
    end
    if (!oldTg || (oldTg && fe)) for (int i = 0; i < 8; i++) mWork[i] = mProg[i];
    if (we) begin
      if (a == 4'd0) begin
        if (d == CODE) mUnl = 1'b1;
        else if (d == 32'd0) mUnl = 1'b0;
      end else if (oldUnl) begin
        if (a == 4'd1) mCtrl = d[4:0];
        else if (a >= 4'd2 && a <= 4'd9) mProg[a - 4'd2] = d;
      end
    end
  endtask

  // driver: one clock edge, model follows, expected item queued
  task automatic tick(logic we, logic [3:0] a, logic [31:0] d);
    regWrEn = we;
    regAddr = a;
    regWrData = d;
    @(posedge clk);
    #1;
    modelEdge(we, a, d);
    q.push_back(mkExp());
    regWrEn = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 32'd0);
  endtask

  task automatic readChk(logic [3:0] a, logic [31:0] expv, string tag);
    regWrEn = 1'b0;
    regAddr = a;
    #1;
    chk($sformatf("%s read addr %0d", tag, a), regRdData, expv);
    tick(1'b0, a, 32'd0);
  endtask

  // monitor: compare each queued item with the outputs, away from the edge
  always @(negedge clk) begin : monitor
    exp_t e;
    if (q.size() != 0) begin
      e = q.pop_front();
      chk({e.tag, "/R4 hCnt"}, 32'(hCnt), 32'(e.h));
      chk({e.tag, "/R4 vCnt"}, 32'(vCnt), 32'(e.v));
      chk({e.tag, e.tg ? "/R6 blank" : "/R5 blank"}, 32'(blank), 32'(e.bl));
      chk({e.tag, "/R7 de"}, 32'(de), 32'(e.de));
      chk({e.tag, "/R8 hsync"}, 32'(hsync), 32'(e.hs));
      chk({e.tag, "/R8 vsync"}, 32'(vsync), 32'(e.vs));
      chk({e.tag, "/R9 fpHsync"}, 32'(fpHsync), 32'(e.fh));
      chk({e.tag, "/R9 fpVsync"}, 32'(fpVsync), 32'(e.fv));
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      summary();
    end
  end

  logic [31:0] prog0[8];

  initial begin : driver
    prog0[0] = 32'h000B_0005; prog0[1] = 32'h000B_0005;
    prog0[2] = 32'h0009_0007; prog0[3] = 32'h0009_0007;
    prog0[4] = 32'h0007_0003; prog0[5] = 32'h0007_0003;
    prog0[6] = 32'h0006_0004; prog0[7] = 32'h0005_0003;
    for (int i = 0; i < 8; i++) begin mProg[i] = '0; mWork[i] = '0; end

    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1: reset state
    chk("R1 hCnt", 32'(hCnt), 0);
    chk("R1 vCnt", 32'(vCnt), 0);
    chk("R1 blank", 32'(blank), 1);
    chk("R1 de", 32'(de), 0);
    chk("R1 syncs", {28'd0, hsync, vsync, fpHsync, fpVsync}, 0);
    readChk(4'd0, 32'd0, "R1");
    readChk(4'd1, 32'd0, "R1");
    readChk(4'd2, 32'd0, "R1");
    readChk(4'd9, 32'd0, "R1");

    // R2: writes while locked are refused, wrong code does not unlock
    phase = "R2";
    tick(1'b1, 4'd2, 32'h000B_0005);
    tick(1'b1, 4'd1, 32'h0000_001F);
    readChk(4'd2, 32'd0, "R2");
    readChk(4'd1, 32'd0, "R2");
    tick(1'b1, 4'd0, 32'h0000_1234);
    readChk(4'd0, 32'd0, "R2");
    tick(1'b1, 4'd0, CODE);
    readChk(4'd0, 32'd1, "R2");

    // R3: program and read back
    for (int i = 0; i < 8; i++) tick(1'b1, 4'(i + 2), prog0[i]);
    for (int i = 0; i < 8; i++) readChk(4'(i + 2), prog0[i], "R3");
    tick(1'b1, 4'd12, 32'hFFFF_FFFF);
    readChk(4'd12, 32'd0, "R3");

    // R2/R3: relock, reads still return stored values, writes refused
    tick(1'b1, 4'd0, 32'd0);
    readChk(4'd0, 32'd0, "R2");
    readChk(4'd2, prog0[0], "R3");
    tick(1'b1, 4'd2, 32'h00FF_00FF);
    readChk(4'd2, prog0[0], "R2");

    // R5/R4/R6..R9: start the raster and run two frames
    tick(1'b1, 4'd0, CODE);
    phase = "R5";
    tick(1'b1, 4'd1, 32'h0000_001F);
    phase = "R4";
    idle(12 * 8 * 2 + 7);

    // R10: mid-frame timing writes, deferred to the frame wrap
    phase = "R10";
    tick(1'b1, 4'd4, 32'h000A_0006);
    readChk(4'd4, 32'h000A_0006, "R10");
    idle(17);
    tick(1'b1, 4'd6, 32'h0009_0003);
    tick(1'b1, 4'd8, 32'h0008_0005);
    idle(12 * 10 * 3 + 11);

    // R8: syncs disabled, blank still active
    phase = "R8";
    tick(1'b1, 4'd1, 32'h0000_0003);
    idle(130);
    // R6: blank enable cleared forces blank
    phase = "R6";
    tick(1'b1, 4'd1, 32'h0000_0001);
    idle(60);
    // R9: flat-panel syncs alone
    phase = "R9";
    tick(1'b1, 4'd1, 32'h0000_0011);
    idle(130);
    // R5: stop, then restart
    phase = "R5";
    tick(1'b1, 4'd1, 32'h0000_0000);
    idle(20);
    tick(1'b1, 4'd1, 32'h0000_001F);
    idle(50);

    // R2: locked write while running has no effect on the raster
    phase = "R2";
    tick(1'b1, 4'd0, 32'd0);
    tick(1'b1, 4'd2, 32'h0003_0001);
    tick(1'b1, 4'd1, 32'h0000_0000);
    idle(12 * 10 + 40);
    readChk(4'd2, 32'h000B_0005, "R2");
    readChk(4'd1, 32'h0000_001F, "R2");

    @(negedge clk);
    #1;
    done = 1;
    summary();
  end
endmodule